// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets synchronous on-chip logic use an external asynchronous static RAM of 8192 bytes. Logic inside the chip presents a request with a write flag, a 13-bit address and a write byte. The controller takes it when it signals ready, then drives the memory pins through a timed read or write sequence. A read returns its byte on a one-cycle valid pulse. Each minimum interval the memory requires (access time, cycle time, write-enable pulse width, data setup to write end, hold after write end) is given in picoseconds. The controller converts each one to whole clock cycles by rounding up, with at least one cycle per phase, so the same RTL serves any clock period.

Writes are ended by write enable. The address and both chip selects stay stable from one cycle before write enable falls until one cycle after it rises. The byte is driven only while write enable is low and during the hold cycle after it, and output enable stays high for the whole write, so the memory never drives the bus at the same time as the controller. When no access is running, both chip selects are inactive, which puts the memory in its low-power deselected state. After reset no access starts until a power-up interval, 100 µs by default, has passed.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset is released, req_ready stays low and mem_sel_n stays high for exactly PWR_CYC clock cycles, where PWR_CYC = ceil(T_POWERUP_PS / CLK_PERIOD_PS) (20000 cycles at the defaults), even if a request is already waiting.
- R2: In reset, and in every cycle with no access in progress, mem_sel_n = 1, mem_sel = 0, mem_we_n = 1, mem_oe_n = 1 and mem_dq_oe = 0. req_ready is high only in such cycles once the power-up wait is over.
- R3: A write runs as one setup cycle (both selects active, mem_we_n high), then WE_CYC cycles with mem_we_n low, then HOLD_CYC cycles with mem_we_n high again. WE_CYC is the largest of the rounded-up pulse width, data setup and address-to-write-end times (2 at the defaults). HOLD_CYC is 1 at the defaults. mem_addr does not change from the setup cycle to the end of the hold phase.
- R4: mem_dq_oe is high exactly from the first write-enable-low cycle to the end of the hold phase (3 cycles at the defaults). While it is high, mem_dq_out carries the accepted write byte and mem_oe_n is high. The byte present when mem_we_n rises is the one that was requested.
- R5: A read keeps both selects active, mem_oe_n low, mem_we_n high and mem_dq_oe low for RD_CYC cycles, the larger of the rounded-up access and read cycle times (2 at the defaults). mem_dq_in is sampled at the clock edge that ends this phase. rsp_valid is high for exactly one cycle, right after that edge.
- R6: A request is accepted at a rising clock edge where req_valid and req_ready are both high. Address and write byte are registered at that edge, and req_ready is low in the next cycle.
- R7: A read returns the byte most recently written to that address, including addresses 0 and 8191 and the bytes 00, FF, AA, 55 and C3.
- R8: A request presented in the cycle where rsp_valid is high is accepted at the end of that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Request address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller can accept a request |
| rsp_rdata | output | 8 | Byte returned by a read |
| rsp_valid | output | 1 | One-cycle pulse marking rsp_rdata valid |
| mem_addr | output | 13 | Memory address pins |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Byte driven toward the data pins |
| mem_dq_oe | output | 1 | Tri-state enable for mem_dq_out |
| mem_dq_in | input | 8 | Byte read from the data pins |

## Verification
Two events can fall in the same cycle: the read result comes back on rsp_valid, and the controller becomes ready for the next request, which is then taken at the end of that cycle. The bench issues requests back to back, so the next request is already waiting when a read's result returns. The scoreboard records how often rsp_valid and an accepted handshake share a cycle, and it checks that the returned byte, the new request's pin sequence and its own result are all still correct. A second overlap is provoked by holding a write request from reset onward, so that the end of the power-up wait and the handshake land on the same edge.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   // State code bits map straight onto pin functions:
   // [3] select active, [2] write enable active, [1] output enable active, [0] bus driven
   typedef enum logic [3:0] {
      ST_IDLE   = 4'b0000,
      ST_WSETUP = 4'b1000,
      ST_WPULSE = 4'b1101,
      ST_WHOLD  = 4'b1001,
      ST_RACC   = 4'b1010
   } seq_state_e;

   // Whole cycles covering a time in ps, never less than one
   function automatic int unsigned ps_to_cyc(input int unsigned t_ps,
                                             input int unsigned clk_ps);
      int unsigned c;
      c = (t_ps + clk_ps - 1) / clk_ps;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_pwrup_timer.sv
module sram_pwrup_timer #(
   parameter bit          ENABLE = 1'b1,
   parameter int unsigned CYCLES = 20000
) (
   input  logic clk,
   input  logic rst_n,
   output logic done
);
   localparam int unsigned CW = $clog2(CYCLES + 1);

   generate
      if (ENABLE) begin : g_wait
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     cnt_q <= '0;
            else if (cnt_q != CW'(CYCLES))  cnt_q <= cnt_q + 1'b1;
         end
         assign done = (cnt_q == CW'(CYCLES));
      end else begin : g_nowait
         assign done = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
   import sram_seq_pkg::*;
#(
   parameter int unsigned WE_CYC   = 2,
   parameter int unsigned HOLD_CYC = 1,
   parameter int unsigned RD_CYC   = 2,
   parameter int unsigned CNT_W    = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_done,
   input  logic       req_valid,
   input  logic       req_write,
   output seq_state_e state,
   output logic       ready,
   output logic       accept,
   output logic       sample
);
   logic [CNT_W-1:0] cnt_q;
   logic             last;

   assign last   = (cnt_q == '0);
   assign ready  = (state == ST_IDLE) && pwr_done;
   assign accept = ready && req_valid;
   assign sample = (state == ST_RACC) && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  state <= req_write ? ST_WSETUP : ST_RACC;
                  cnt_q <= req_write ? '0 : CNT_W'(RD_CYC - 1);
               end
            end
            ST_WSETUP: begin
               state <= ST_WPULSE;
               cnt_q <= CNT_W'(WE_CYC - 1);
            end
            ST_WPULSE: begin
               if (last) begin
                  state <= ST_WHOLD;
                  cnt_q <= CNT_W'(HOLD_CYC - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_WHOLD, ST_RACC: begin
               if (last) state <= ST_IDLE;
               else      cnt_q <= cnt_q - 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // An accepted request always leaves idle on the next cycle
   assert_accept_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (state != ST_IDLE));

endmodule

// File: rtl/sram_req_capture.sv
module sram_req_capture #(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              sample,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q,
   output logic              rvalid_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= sample;
         if (sample) rdata_q <= mem_dq_in;
      end
   end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
   import sram_seq_pkg::*;
#(
   parameter int unsigned ADDR_W        = 13,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned CLK_PERIOD_PS = 5000,
   parameter int unsigned T_ACCESS_PS   = 10000,
   parameter int unsigned T_RCYCLE_PS   = 10000,
   parameter int unsigned T_WEPULSE_PS  = 7000,
   parameter int unsigned T_DSETUP_PS   = 6000,
   parameter int unsigned T_AWEND_PS    = 7000,
   parameter int unsigned T_DHOLD_PS    = 0,
   parameter bit          PWRUP_EN      = 1'b1,
   parameter int unsigned T_POWERUP_PS  = 100_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_sel_n,
   output logic              mem_sel,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   localparam int unsigned WE_CYC   = max2(ps_to_cyc(T_WEPULSE_PS, CLK_PERIOD_PS),
                                      max2(ps_to_cyc(T_DSETUP_PS, CLK_PERIOD_PS),
                                           ps_to_cyc(T_AWEND_PS, CLK_PERIOD_PS)));
   localparam int unsigned HOLD_CYC = ps_to_cyc(T_DHOLD_PS, CLK_PERIOD_PS);
   localparam int unsigned RD_CYC   = max2(ps_to_cyc(T_ACCESS_PS, CLK_PERIOD_PS),
                                           ps_to_cyc(T_RCYCLE_PS, CLK_PERIOD_PS));
   localparam int unsigned PWR_CYC  = ps_to_cyc(T_POWERUP_PS, CLK_PERIOD_PS);
   localparam int unsigned MAX_CYC  = max2(WE_CYC, max2(HOLD_CYC, RD_CYC));
   localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

   // Elaboration-time parameter checks
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_seq_ctrl: address and data widths must be nonzero");
   end
   if (CLK_PERIOD_PS == 0) begin : g_bad_clk
      $error("sram_seq_ctrl: clock period must be nonzero");
   end

   seq_state_e        state;
   logic              pwr_done;
   logic              accept;
   logic              sample;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   sram_pwrup_timer #(
      .ENABLE (PWRUP_EN),
      .CYCLES (PWR_CYC)
   ) u_pwrup (
      .clk   (clk),
      .rst_n (rst_n),
      .done  (pwr_done)
   );

   sram_phase_seq #(
      .WE_CYC   (WE_CYC),
      .HOLD_CYC (HOLD_CYC),
      .RD_CYC   (RD_CYC),
      .CNT_W    (CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_done  (pwr_done),
      .req_valid (req_valid),
      .req_write (req_write),
      .state     (state),
      .ready     (req_ready),
      .accept    (accept),
      .sample    (sample)
   );

   sram_req_capture #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .sample    (sample),
      .mem_dq_in (mem_dq_in),
      .addr_q    (addr_q),
      .wdata_q   (wdata_q),
      .rdata_q   (rsp_rdata),
      .rvalid_q  (rsp_valid)
   );

   // Pins come straight from state flops: no decode glitches on strobes
   assign mem_sel    =  state[3];
   assign mem_sel_n  = ~state[3];
   assign mem_we_n   = ~state[2];
   assign mem_oe_n   = ~state[1];
   assign mem_dq_oe  =  state[0];
   assign mem_addr   =  addr_q;
   assign mem_dq_out =  wdata_q;

   assert_pwrup_block_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_done |-> (mem_sel_n && !req_ready));

   assert_idle_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe));

   assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_sel && $past(mem_sel)) |-> $stable(mem_addr));

   assert_data_at_write_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && mem_sel && $stable(mem_dq_out)));

   assert_drive_during_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_dq_oe);

   assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   assert_read_we_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (mem_we_n && mem_sel));

   assert_rvalid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

// File: tb/sram_seq_ctrl_bench.sv
`timescale 1ns/1ps
module sram_seq_ctrl_bench;
   localparam int WE_LOW_EXP = 2;      // R3: ceil(7000/5000)
   localparam int DRIVE_EXP  = 3;      // R4: WE low cycles plus one hold cycle
   localparam int RD_EXP     = 2;      // R5: ceil(10000/5000)
   localparam int PWR_EXP    = 20000;  // R1: 100 us at 5 ns

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [12:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready;
   logic [7:0]  rsp_rdata;
   logic        rsp_valid;
   logic [12:0] mem_addr;
   logic        mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [7:0]  mem_dq_out;
   logic [7:0]  mem_dq_in = 8'hEE;

   always #2.5 clk = ~clk;

   sram_seq_ctrl u_sram_seq_ctrl (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata), .req_ready (req_ready),
      .rsp_rdata (rsp_rdata), .rsp_valid (rsp_valid),
      .mem_addr (mem_addr), .mem_sel_n (mem_sel_n), .mem_sel (mem_sel),
      .mem_we_n (mem_we_n), .mem_oe_n (mem_oe_n),
      .mem_dq_out (mem_dq_out), .mem_dq_oe (mem_dq_oe), .mem_dq_in (mem_dq_in)
   );

   int checks = 0;
   int errors = 0;
   int overlap = 0;
   int reads_issued = 0;
   int reads_seen = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Memory model and reference
   logic [7:0] model [int];
   logic [7:0] refm  [int];
   logic [7:0] rd_q [$];
   logic [12:0] wa_q [$];
   logic [7:0]  wd_q [$];
   int age = 0;

   always @(posedge clk) begin
      if (!rst_n) age <= 0;
      else if (!mem_oe_n && mem_sel && !mem_sel_n && mem_we_n) age <= age + 1;
      else age <= 0;
   end

   always @(negedge clk) begin
      if (!mem_oe_n && mem_sel && !mem_sel_n && mem_we_n && age >= RD_EXP - 1)
         mem_dq_in = model.exists(int'(mem_addr)) ? model[int'(mem_addr)] : 8'h00;
      else
         mem_dq_in = 8'hEE;
   end

   // Write end: capture what the pins hold as write enable rises
   always @(posedge mem_we_n) begin
      if (rst_n === 1'b1 && mem_dq_oe === 1'b1 && mem_sel === 1'b1) begin
         if (wa_q.size() == 0) chk(0, "R4", "unexpected write", 0, 1);
         else begin
            logic [12:0] ea;
            logic [7:0]  ed;
            ea = wa_q.pop_front();
            ed = wd_q.pop_front();
            chk(mem_addr == ea, "R4", "write address at WE rise", mem_addr, ea);
            chk(mem_dq_out == ed, "R4", "write byte at WE rise", mem_dq_out, ed);
         end
         model[int'(mem_addr)] = mem_dq_out;
      end
   end

   // Monitor: pin sequence and scoreboard
   int we_run = 0, drv_run = 0, oe_run = 0;
   logic [12:0] run_addr = '0;
   logic prev_rv = 1'b0, prev_setup = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (req_ready)
            chk(mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe,
                "R2", "idle pins", {mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
         if (prev_setup) chk(!mem_we_n, "R3", "WE low after setup", mem_we_n, 0);
         prev_setup = mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe;
         if (prev_setup) run_addr = mem_addr;
         if (!mem_we_n) begin
            chk(mem_addr == run_addr, "R3", "address stable in write", mem_addr, run_addr);
            chk(mem_dq_oe && mem_oe_n && mem_sel && !mem_sel_n, "R4", "drive during WE low",
                {mem_dq_oe, mem_oe_n, mem_sel}, 3'b111);
            we_run++;
         end else if (we_run != 0) begin
            chk(we_run == WE_LOW_EXP, "R3", "WE low length", we_run, WE_LOW_EXP);
            chk(mem_addr == run_addr && mem_sel, "R3", "address held in hold", mem_addr, run_addr);
            we_run = 0;
         end
         if (mem_dq_oe) drv_run++;
         else if (drv_run != 0) begin
            chk(drv_run == DRIVE_EXP, "R4", "drive window length", drv_run, DRIVE_EXP);
            drv_run = 0;
         end
         if (!mem_oe_n) begin
            chk(mem_we_n && !mem_dq_oe && mem_sel, "R5", "read pins", {mem_we_n, mem_dq_oe}, 2'b10);
            oe_run++;
         end else if (oe_run != 0) begin
            chk(oe_run == RD_EXP, "R5", "read phase length", oe_run, RD_EXP);
            oe_run = 0;
         end
         if (rsp_valid) begin
            chk(!prev_rv, "R5", "rsp_valid single pulse", prev_rv, 0);
            reads_seen++;
            if (rd_q.size() == 0) chk(0, "R5", "unexpected rsp_valid", 1, 0);
            else begin
               logic [7:0] e;
               e = rd_q.pop_front();
               chk(rsp_rdata == e, "R7", "read data", rsp_rdata, e);
            end
            if (req_valid && req_ready) overlap++;
         end
         prev_rv = rsp_valid;
      end
   end

   // Driver
   task automatic issue(input bit w, input logic [12:0] a, input logic [7:0] d);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      if (w) begin
         refm[int'(a)] = d;
         wa_q.push_back(a);
         wd_q.push_back(d);
      end else begin
         rd_q.push_back(refm.exists(int'(a)) ? refm[int'(a)] : 8'h00);
         reads_issued++;
      end
      @(negedge clk);
      chk(!req_ready && mem_sel, "R6", "ready drops after accept", req_ready, 0);
      req_valid = 1'b0;
      req_addr  = ~a;
      req_wdata = ~d;
   endtask

   task automatic pwr_watch();
      int low = 0;
      bit quiet = 1'b1;
      while (!req_ready) begin
         if (!mem_sel_n) quiet = 1'b0;
         low++;
         @(negedge clk);
      end
      chk(low == PWR_EXP, "R1", "power-up wait cycles", low, PWR_EXP);
      chk(quiet, "R1", "no select during power-up", quiet, 1);
   endtask

   bit timeout = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      chk(!req_ready && mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
          "R2", "reset pins", {req_ready, mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe},
          6'b010110);
      fork
         begin
            rst_n = 1'b1;
            fork
               pwr_watch();
               issue(1'b1, 13'd5, 8'h3C);
            join
            issue(1'b1, 13'd0,    8'h00);
            issue(1'b1, 13'd8191, 8'hFF);
            issue(1'b1, 13'd1,    8'hAA);
            issue(1'b1, 13'd2,    8'h55);
            issue(1'b1, 13'd100,  8'hC3);
            issue(1'b0, 13'd0,    8'h00);
            issue(1'b0, 13'd8191, 8'h00);
            issue(1'b0, 13'd1,    8'h00);
            issue(1'b0, 13'd2,    8'h00);
            issue(1'b0, 13'd100,  8'h00);
            issue(1'b0, 13'd5,    8'h00);
            issue(1'b1, 13'd1,    8'h5A);
            issue(1'b0, 13'd1,    8'h00);
            issue(1'b0, 13'd8191, 8'h00);
            repeat (10) @(negedge clk);
         end
         begin
            repeat (150000) @(posedge clk);
            timeout = 1'b1;
         end
      join_any
      if (timeout) chk(0, "R1", "watchdog expired", 1, 0);
      chk(rd_q.size() == 0 && reads_seen == reads_issued, "R7", "all reads returned",
          reads_seen, reads_issued);
      chk(wa_q.size() == 0, "R4", "all writes reached pins", wa_q.size(), 0);
      chk(overlap > 0, "R8", "request taken in rsp_valid cycle", overlap, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule